// File: doc/BRIEF.md
# Register-Amount Shifter with Carry Flag

This block shifts or rotates a data word by an amount taken from a second register operand and produces the shifted word together with an updated carry flag. Four operations are supported: logical shift left, logical shift right, arithmetic shift right and rotate right. The carry follows the full rules for large amounts. An amount equal to the word width, or larger, gives a defined result and carry. The block does not simply reduce the amount modulo the word width the way a plain barrel shifter would.

A caller presents the operand word, the amount register, the operation code and the current carry together with a valid strobe. One clock later the result and the new carry appear on registered outputs with a matching valid flag. Those outputs keep their values until the next strobe.

Top module: `shift_carry_unit`

## Requirements
- R1: Only the low eight bits of `in_amount` form the shift amount. The upper 24 bits have no effect on the result or the carry.
- R2: When the shift amount is 0, for every operation code, the result equals `in_value` and the carry equals `in_carry`.
- R3: Operation code 2'b00 is logical left. For an amount n in 1..31, the carry is input bit (32-n). For n = 32 the result is 0 and the carry is input bit 0. For n above 32 the result is 0 and the carry is 0.
- R4: Operation code 2'b01 is logical right. For n in 1..31, the carry is input bit (n-1). For n = 32 the result is 0 and the carry is input bit 31. For n above 32 both the result and the carry are 0.
- R5: Operation code 2'b10 is arithmetic right. For n in 1..31, the vacated bits take the sign bit and the carry is input bit (n-1). For n of 32 or more, every result bit and the carry equal input bit 31.
- R6: Operation code 2'b11 is rotate right by n modulo 32. When n modulo 32 is nonzero, the word rotates by that count and the carry is input bit ((n mod 32)-1).
- R7: For rotate right, a nonzero amount whose low five bits are zero returns the input word unchanged, with the carry set to input bit 31.
- R8: The result and carry are registered. They appear one clock after a cycle with `in_valid` high, and `out_valid` is high in exactly that cycle. While `in_valid` is low, `out_value` and `out_carry` hold their values.
- R9: During and after reset, before any strobe, `out_valid`, `out_value` and `out_carry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_value | input | 32 | Word to shift |
| in_amount | input | 32 | Amount register; only bits 7:0 are used |
| in_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| out_value | output | 32 | Shifted word |
| out_carry | output | 1 | Updated carry flag |

## Verification
The bench builds the block with its defaults: a 32-bit word and an 8-bit amount field. With these values every legal amount, 0 through 255, can be swept exhaustively for each operation. That sweep reaches the boundary at exactly the word width, the amounts just above it, and every nonzero multiple of 32 that exercises the rotate special case. Because the amount field is narrower than the 32-bit operand port, the bench can also show that the upper operand bits are discarded.

// File: rtl/shc_pkg.sv
package shc_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/shc_left.sv
module shc_left #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cry_o
);
    // One guard bit above the word catches the last bit shifted out.
    logic [DATA_W:0] wide;

    always_comb begin
        wide  = {1'b0, val_i} << amt_i;
        res_o = wide[DATA_W-1:0];
        cry_o = wide[DATA_W];
    end
endmodule

// File: rtl/shc_right.sv
module shc_right #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter bit ARITH  = 1'b0
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cry_o
);
    // One guard bit below the word catches the last bit shifted out.
    logic [DATA_W:0] wide;

    generate
        if (ARITH) begin : g_arith
            always_comb wide = $unsigned($signed({val_i, 1'b0}) >>> amt_i);
        end else begin : g_logic
            always_comb wide = {val_i, 1'b0} >> amt_i;
        end
    endgenerate

    always_comb begin
        res_o = wide[DATA_W:1];
        cry_o = wide[0];
    end
endmodule

// File: rtl/shc_rotate.sv
module shc_rotate #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cry_o
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0] rot;

    always_comb begin
        rot = amt_i[IDX_W-1:0];
        if (rot == '0) begin
            res_o = val_i;
        end else begin
            res_o = (val_i >> rot) | (val_i << (DATA_W - int'(rot)));
        end
        // For any nonzero amount, the carry is the new top bit.
        cry_o = res_o[DATA_W-1];
    end
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit #(
    parameter int DATA_W = 32,
    parameter int OPER_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic [OPER_W-1:0] in_amount,
    input  logic [1:0]        in_kind,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_carry
);
    import shc_pkg::*;

    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] value;
        logic              carry;
    } shc_state_t;

    shc_state_t st_d, st_q;

    logic [AMT_W-1:0] amt;
    logic             unused_amount_hi;
    shift_kind_e      kind;

    assign amt              = in_amount[AMT_W-1:0];
    assign unused_amount_hi = ^in_amount[OPER_W-1:AMT_W];
    assign kind             = shift_kind_e'(in_kind);

    logic [DATA_W-1:0] lsl_res, lsr_res, asr_res, ror_res;
    logic              lsl_cry, lsr_cry, asr_cry, ror_cry;

    shc_left #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lsl (
        .val_i(in_value), .amt_i(amt), .res_o(lsl_res), .cry_o(lsl_cry)
    );

    shc_right #(.DATA_W(DATA_W), .AMT_W(AMT_W), .ARITH(1'b0)) u_lsr (
        .val_i(in_value), .amt_i(amt), .res_o(lsr_res), .cry_o(lsr_cry)
    );

    shc_right #(.DATA_W(DATA_W), .AMT_W(AMT_W), .ARITH(1'b1)) u_asr (
        .val_i(in_value), .amt_i(amt), .res_o(asr_res), .cry_o(asr_cry)
    );

    shc_rotate #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_ror (
        .val_i(in_value), .amt_i(amt), .res_o(ror_res), .cry_o(ror_cry)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (amt == '0) begin
                st_d.value = in_value;
                st_d.carry = in_carry;
            end else begin
                unique case (kind)
                    SH_LSL:  begin st_d.value = lsl_res; st_d.carry = lsl_cry; end
                    SH_LSR:  begin st_d.value = lsr_res; st_d.carry = lsr_cry; end
                    SH_ASR:  begin st_d.value = asr_res; st_d.carry = asr_cry; end
                    default: begin st_d.value = ror_res; st_d.carry = ror_cry; end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_value = st_q.value;
    assign out_carry = st_q.carry;

    // Checks at the ports, one cycle after the strobe.
    assert_zero_amount_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt == '0) |=> (out_value == $past(in_value) && out_carry == $past(in_carry)));

    assert_lsl_beyond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b00 && int'(amt) > DATA_W) |=> (out_value == '0 && !out_carry));

    assert_lsr_beyond_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b01 && int'(amt) > DATA_W) |=> (out_value == '0 && !out_carry));

    assert_asr_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b10 && int'(amt) >= DATA_W)
        |=> (out_value == {DATA_W{$past(in_value[DATA_W-1])}} && out_carry == $past(in_value[DATA_W-1])));

    assert_ror_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b11 && amt != '0) |=> (out_carry == out_value[DATA_W-1]));

    assert_ror_whole_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b11 && amt != '0 && amt[IDX_W-1:0] == '0)
        |=> (out_value == $past(in_value)));

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_value) && $stable(out_carry) && !out_valid));

endmodule

// File: tb/tb_shift_carry_unit.sv
`timescale 1ns/1ps
module tb_shift_carry_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [31:0] in_amount = '0;
    logic [1:0]  in_kind = 2'b00;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_carry;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shift_carry_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_amount(in_amount), .in_kind(in_kind), .in_carry(in_carry),
        .out_valid(out_valid), .out_value(out_value), .out_carry(out_carry)
    );

    // Step-by-step reference: one bit position per iteration.
    task automatic model(input logic [31:0] v, input int n, input logic [1:0] k,
                         input logic ci, output logic [31:0] rv, output logic rc);
        rv = v;
        rc = ci;
        if (n == 0) return;
        if (k == 2'b11) begin
            for (int i = 0; i < (n % 32); i++) begin
                rc = rv[0];
                rv = {rv[0], rv[31:1]};
            end
            if (n % 32 == 0) rc = v[31];
        end else begin
            for (int i = 0; i < n; i++) begin
                if (k == 2'b00) begin
                    rc = rv[31];
                    rv = {rv[30:0], 1'b0};
                end else if (k == 2'b01) begin
                    rc = rv[0];
                    rv = {1'b0, rv[31:1]};
                end else begin
                    rc = rv[0];
                    rv = {rv[31], rv[31:1]};
                end
            end
        end
    endtask

    task automatic check(input string req, input logic [31:0] got_v, input logic got_c,
                         input logic [31:0] exp_v, input logic exp_c);
        checks++;
        if (got_v !== exp_v || got_c !== exp_c) begin
            errors++;
            $display("FAIL %s: actual value=%h carry=%b, expected value=%h carry=%b",
                     req, got_v, got_c, exp_v, exp_c);
        end
    endtask

    task automatic run_op(input logic [31:0] v, input logic [31:0] amt_reg,
                          input logic [1:0] k, input logic ci);
        @(negedge clk);
        in_valid  = 1'b1;
        in_value  = v;
        in_amount = amt_reg;
        in_kind   = k;
        in_carry  = ci;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset", out_value, out_carry, 32'h0, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9 valid: actual %b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset", out_value, out_carry, 32'h0, 1'b0);
    endtask

    task automatic t_sweep();
        logic [31:0] pats [3] = '{32'h8000_0001, 32'h5A3C_96E1, 32'h7FFF_FFFE};
        logic [31:0] ev;
        logic        ec;
        string       tag;
        for (int k = 0; k < 4; k++) begin
            tag = (k == 0) ? "R3 lsl" : (k == 1) ? "R4 lsr" : (k == 2) ? "R5 asr" : "R6/R7 ror";
            for (int p = 0; p < 3; p++) begin
                for (int n = 0; n < 256; n++) begin
                    logic ci;
                    ci = logic'((n + p) & 1);
                    model(pats[p], n, 2'(k), ci, ev, ec);
                    run_op(pats[p], 32'(n), 2'(k), ci);
                    check(n == 0 ? "R2 zero amount" : tag, out_value, out_carry, ev, ec);
                    checks++;
                    if (out_valid !== 1'b1) begin
                        errors++;
                        $display("FAIL R8 valid: actual %b expected 1", out_valid);
                    end
                end
            end
        end
    endtask

    task automatic t_boundaries();
        run_op(32'h0000_0001, 32'd32, 2'b00, 1'b0);
        check("R3 lsl by 32", out_value, out_carry, 32'h0, 1'b1);
        run_op(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1);
        check("R3 lsl by 33", out_value, out_carry, 32'h0, 1'b0);
        run_op(32'h8000_0000, 32'd32, 2'b01, 1'b0);
        check("R4 lsr by 32", out_value, out_carry, 32'h0, 1'b1);
        run_op(32'hFFFF_FFFF, 32'd200, 2'b01, 1'b1);
        check("R4 lsr by 200", out_value, out_carry, 32'h0, 1'b0);
        run_op(32'h8000_0000, 32'd40, 2'b10, 1'b0);
        check("R5 asr by 40", out_value, out_carry, 32'hFFFF_FFFF, 1'b1);
        run_op(32'h7000_0000, 32'd255, 2'b10, 1'b1);
        check("R5 asr by 255 positive", out_value, out_carry, 32'h0, 1'b0);
        run_op(32'h0000_000F, 32'd4, 2'b11, 1'b0);
        check("R6 ror by 4", out_value, out_carry, 32'hF000_0000, 1'b1);
        run_op(32'h8000_0001, 32'd64, 2'b11, 1'b0);
        check("R7 ror by 64", out_value, out_carry, 32'h8000_0001, 1'b1);
        run_op(32'h1234_5678, 32'd0, 2'b11, 1'b1);
        check("R2 ror by 0", out_value, out_carry, 32'h1234_5678, 1'b1);
    endtask

    task automatic t_upper_ignored();
        run_op(32'hCAFE_F00D, 32'hFFFF_FF00, 2'b00, 1'b1);
        check("R1 upper bits, amount 0", out_value, out_carry, 32'hCAFE_F00D, 1'b1);
        run_op(32'h0000_0003, 32'hABCD_0101, 2'b00, 1'b0);
        check("R1 upper bits, amount 1", out_value, out_carry, 32'h0000_0006, 1'b0);
        run_op(32'h8000_0000, 32'h0001_0020, 2'b01, 1'b0);
        check("R1 upper bits, amount 32", out_value, out_carry, 32'h0, 1'b1);
    endtask

    task automatic t_hold();
        run_op(32'h0000_00F0, 32'd4, 2'b01, 1'b1);
        check("R8 result", out_value, out_carry, 32'h0000_000F, 1'b0);
        in_value  = 32'hFFFF_FFFF;
        in_amount = 32'd1;
        in_kind   = 2'b00;
        in_carry  = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 hold without strobe", out_value, out_carry, 32'h0000_000F, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 valid low: actual %b expected 0", out_valid);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sweep();
        t_boundaries();
        t_upper_ignored();
        t_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule